// File: doc/BRIEF.md
# Four-Channel DMA Controller

This block moves data between memory and peripherals while the processor stays off the bus. Each of four peripherals has its own request line. When an enabled channel with work left raises its request, the controller raises a hold request and waits for the processor's hold acknowledge. Only then does it take the bus. It serves one channel per transfer. During that transfer it drives a 16-bit memory address, pulls that channel's active-low acknowledge, and asserts the pair of strobes that match the channel's cycle type. Only the addressing and strobe timing are produced; the data itself passes outside the block.

Software sets up each channel while the controller acts as a bus slave. It writes a start address, a 14-bit transfer count with a two-bit cycle type, and an enable bit. After every transfer the address steps up by one and the count steps down by one. A terminal-count pulse marks the transfer that empties the count, and the channel then switches itself off. When no enabled channel still has a request, the controller releases the bus.

Top module: `dma4_ctrl`

## Requirements
- R1: Requests are served at fixed priority, channel 0 highest and channel 3 lowest. The winner is chosen only between transfers: a higher request that arrives during a transfer waits for that transfer to end, then wins the next one.
- R2: `hrq` rises when an eligible channel requests. While `hlda` stays low, all acknowledges remain high, all strobes remain high and `mem_addr` stays 0.
- R3: `dack_n` is active low. At most one bit is low at a time, and it stays low for exactly four clock states per transfer.
- R4: Cycle type 2'b10 (read) pulls `mem_rd_n` and `io_wr_n` low in states 2 and 3 of the transfer. Type 2'b01 (write) pulls `io_rd_n` and `mem_wr_n` low in those same states. Type 2'b00 or 2'b11 (verify) asserts no strobe. All strobes are high in states 1 and 4.
- R5: `mem_addr` shows the channel's address for the whole transfer. After the transfer the address increments by one and wraps from 0xFFFF to 0x0000.
- R6: Each transfer decrements the channel's count by one. `tc` is high in state 4 of the transfer that takes the count from 1 to 0, and that channel is then disabled, so its request is ignored afterwards.
- R7: `hrq` drops after the last transfer when no eligible channel requests.
- R8: A configuration write selects the channel with `cfg_addr[3:2]` and the register with `cfg_addr[1:0]`. Code 0 writes the 16-bit address. Code 1 writes the count in `cfg_wdata[13:0]` and the cycle type in `cfg_wdata[15:14]`. Code 2 writes the enable bit from `cfg_wdata[0]`. Code 3 does nothing.
- R9: Configuration writes are ignored while `hlda` is high.
- R10: A channel is eligible only when it is enabled and its count is not zero. A request from any other channel does not raise `hrq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Channel (bits 3:2) and register code (bits 1:0) |
| cfg_wdata | input | 16 | Configuration write data |
| drq | input | 4 | Peripheral transfer requests, bit n = channel n |
| hlda | input | 1 | Hold acknowledge from the processor |
| hrq | output | 1 | Hold request to the processor |
| dack_n | output | 4 | Active-low acknowledge per channel |
| mem_addr | output | 16 | Memory address during a transfer, 0 otherwise |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | Peripheral read strobe, active low |
| io_wr_n | output | 1 | Peripheral write strobe, active low |
| tc | output | 1 | Terminal-count pulse on the final transfer of a channel |

## Verification
The bench first raises one request on a channel set up for three read transfers. This single-channel run shows address stepping, the final-transfer pulse and the self-disable, because the request is still held once the count is spent. It then raises three requests at once with write, read and verify channels, and adds a top-priority request partway through the first transfer. This second run tells fixed priority apart from first-come order, and shows whether the new winner is picked mid-transfer or only between transfers. Further cases cover an address that wraps past 0xFFFF, a withheld hold acknowledge, and a setup write made while the bus is granted. Requests on disabled and zero-count channels are also checked.

// File: rtl/dma4_pkg.sv
// Shared types for the four-channel DMA controller.
// Assumes: the cycle type is a two-bit field; code 2'b11 behaves as verify.
package dma4_pkg;

    localparam int NCH_DEF = 4;
    localparam int AW_DEF  = 16;
    localparam int CW_DEF  = 14;

    typedef enum logic [1:0] {
        XF_VERIFY = 2'b00,
        XF_WRITE  = 2'b01,
        XF_READ   = 2'b10,
        XF_SPARE  = 2'b11
    } xfer_t;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HOLD = 3'd1,
        ST_S1   = 3'd2,
        ST_S2   = 3'd3,
        ST_S3   = 3'd4,
        ST_S4   = 3'd5
    } seq_state_t;

endpackage

// File: rtl/dma4_regs.sv
// Per-channel register file: address, count, cycle type and enable.
// Channel n is selected by cfg_addr[CAW+1:2]; cfg_addr[1:0] picks the register.
// Writes are dropped while lock (hold acknowledge) is high. The update pulse
// from the sequencer steps address and count, and clears enable on the last count.
// Assumes: AW >= CW + 2, so the type field fits in the top two data bits.
module dma4_regs #(
    parameter int NCH = dma4_pkg::NCH_DEF,
    parameter int AW  = dma4_pkg::AW_DEF,
    parameter int CW  = dma4_pkg::CW_DEF,
    localparam int CAW = $clog2(NCH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [CAW+1:0]           cfg_addr,
    input  logic [AW-1:0]            cfg_wdata,
    input  logic                     lock,
    input  logic                     upd,
    input  logic [CAW-1:0]           upd_ch,
    output logic [NCH-1:0][AW-1:0]   ch_addr,
    output logic [NCH-1:0][1:0]      ch_typ,
    output logic [NCH-1:0]           ch_last,
    output logic [NCH-1:0]           ch_live
);

    logic [CAW-1:0]          wr_ch;
    logic [1:0]              wr_sel;
    logic [NCH-1:0][CW-1:0]  ch_cnt;
    logic [NCH-1:0]          ch_en;

    // Split the configuration address into channel and register code.
    always_comb begin
        wr_ch  = cfg_addr[CAW+1:2];
        wr_sel = cfg_addr[1:0];
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        // Hold one channel's state; the sequencer update wins over a write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ch_addr[g] <= '0;
                ch_cnt[g]  <= '0;
                ch_typ[g]  <= 2'b00;
                ch_en[g]   <= 1'b0;
            end else if (upd && upd_ch == CAW'(g)) begin
                ch_addr[g] <= ch_addr[g] + AW'(1);
                ch_cnt[g]  <= ch_cnt[g] - CW'(1);
                if (ch_cnt[g] == CW'(1)) begin
                    ch_en[g] <= 1'b0;
                end
            end else if (cfg_we && !lock && wr_ch == CAW'(g)) begin
                case (wr_sel)
                    2'd0: ch_addr[g] <= cfg_wdata;
                    2'd1: begin
                        ch_cnt[g] <= cfg_wdata[CW-1:0];
                        ch_typ[g] <= cfg_wdata[AW-1:AW-2];
                    end
                    2'd2: ch_en[g] <= cfg_wdata[0];
                    default: ;
                endcase
            end
        end

        // Flag eligibility and the final count for the sequencer.
        always_comb begin
            ch_live[g] = ch_en[g] && (ch_cnt[g] != '0);
            ch_last[g] = (ch_cnt[g] == CW'(1));
        end

        AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (upd && upd_ch == CAW'(g)) |=> ch_addr[g] == AW'($past(ch_addr[g]) + AW'(1))); // R5
        AST_TC_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (upd && upd_ch == CAW'(g) && ch_cnt[g] == CW'(1)) |=> (!ch_en[g] && ch_cnt[g] == '0)); // R6
        AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (lock && !(upd && upd_ch == CAW'(g))) |=> ($stable(ch_addr[g]) && $stable(ch_cnt[g])
                && $stable(ch_typ[g]) && $stable(ch_en[g]))); // R9
    end

    // Unused-width guard: the type field must sit above the count.
    initial begin
        AST_FIELD_FIT: assert (AW >= CW + 2); // R8
    end

endmodule

// File: rtl/dma4_arb.sv
// Fixed-priority arbiter: the lowest-numbered active request wins.
// Assumes: the caller samples the result only at a decision point.
module dma4_arb #(
    parameter int NCH = dma4_pkg::NCH_DEF,
    localparam int CAW = $clog2(NCH)
) (
    input  logic [NCH-1:0] req,
    output logic [CAW-1:0] win_idx,
    output logic           win_any
);

    logic [NCH-1:0] below;

    // Scan from the lowest priority upward so channel 0 overrides all others.
    always_comb begin
        win_idx = '0;
        win_any = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                win_idx = CAW'(i);
                win_any = 1'b1;
            end
        end
    end

    // Check that the winner is requesting and nobody above it is.
    always_comb begin
        below = (NCH'(1) << win_idx) - NCH'(1);
        if (win_any) begin
            AST_FIXED_PRIO: assert (req[win_idx] && (req & below) == '0); // R1
        end
    end

endmodule

// File: rtl/dma4_seq.sv
// Transfer sequencer: hold handshake, four-state transfer timing, strobes,
// acknowledge and terminal count. It picks a channel in the hold state or at
// the last state of a transfer; the channel finishing its count is masked out
// of that pick. Assumes hlda stays high once granted until hrq drops.
module dma4_seq #(
    parameter int NCH = dma4_pkg::NCH_DEF,
    parameter int AW  = dma4_pkg::AW_DEF,
    localparam int CAW = $clog2(NCH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hlda,
    input  logic [NCH-1:0]          drq,
    input  logic [NCH-1:0]          ch_live,
    input  logic [NCH-1:0]          ch_last,
    input  logic [NCH-1:0][AW-1:0]  ch_addr,
    input  logic [NCH-1:0][1:0]     ch_typ,
    input  logic                    arb_any,
    input  logic [CAW-1:0]          arb_idx,
    output logic [NCH-1:0]          arb_req,
    output logic                    hrq,
    output logic [NCH-1:0]          dack_n,
    output logic [AW-1:0]           mem_addr,
    output logic                    mem_rd_n,
    output logic                    mem_wr_n,
    output logic                    io_rd_n,
    output logic                    io_wr_n,
    output logic                    tc,
    output logic                    upd,
    output logic [CAW-1:0]          upd_ch
);
    import dma4_pkg::*;

    seq_state_t     state;
    logic [CAW-1:0] cur;
    logic           busy;
    logic           strobe;
    logic           ending;
    xfer_t          typ;

    // Offer eligible requests to the arbiter, minus a channel on its last count.
    always_comb begin
        ending  = (state == ST_S4) && ch_last[cur];
        arb_req = drq & ch_live & ~(ending ? (NCH'(1) << cur) : '0);
    end

    // Step through idle, hold wait and the four transfer states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cur   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (arb_any) state <= ST_HOLD;
                ST_HOLD: begin
                    if (!arb_any) begin
                        state <= ST_IDLE;
                    end else if (hlda) begin
                        state <= ST_S1;
                        cur   <= arb_idx;
                    end
                end
                ST_S1: state <= ST_S2;
                ST_S2: state <= ST_S3;
                ST_S3: state <= ST_S4;
                ST_S4: begin
                    if (!arb_any) begin
                        state <= ST_IDLE;
                    end else if (hlda) begin
                        state <= ST_S1;
                        cur   <= arb_idx;
                    end else begin
                        state <= ST_HOLD;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive bus outputs from the state and the channel being served.
    always_comb begin
        busy     = (state == ST_S1) || (state == ST_S2) || (state == ST_S3) || (state == ST_S4);
        strobe   = (state == ST_S2) || (state == ST_S3);
        typ      = xfer_t'(ch_typ[cur]);
        hrq      = (state != ST_IDLE);
        dack_n   = busy ? ~(NCH'(1) << cur) : '1;
        mem_addr = busy ? ch_addr[cur] : '0;
        mem_rd_n = !(strobe && typ == XF_READ);
        io_wr_n  = !(strobe && typ == XF_READ);
        io_rd_n  = !(strobe && typ == XF_WRITE);
        mem_wr_n = !(strobe && typ == XF_WRITE);
        tc       = ending;
        upd      = (state == ST_S4);
        upd_ch   = cur;
    end

    AST_ONE_DACK: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~dack_n)); // R3
    AST_WAIT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !hlda) |=> (dack_n == '1 && mem_addr == '0)); // R2
    AST_STROBE_NEEDS_DACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n || !mem_wr_n || !io_rd_n || !io_wr_n) |-> (dack_n != '1)); // R4
    AST_STROBE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_n == io_wr_n) && (mem_wr_n == io_rd_n) && (mem_rd_n || mem_wr_n)); // R4
    AST_TC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> (dack_n != '1 && mem_rd_n && mem_wr_n && io_rd_n && io_wr_n)); // R6
    AST_HRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_S4 && !arb_any) |=> !hrq); // R7

endmodule

// File: rtl/dma4_ctrl.sv
// Top of the four-channel DMA controller: register file, fixed-priority
// arbiter and transfer sequencer. Configuration writes are locked out while
// the bus is granted. Assumes a single clock and synchronous active-low reset.
module dma4_ctrl (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [3:0]  cfg_addr,
    input  logic [15:0] cfg_wdata,
    input  logic [3:0]  drq,
    input  logic        hlda,
    output logic        hrq,
    output logic [3:0]  dack_n,
    output logic [15:0] mem_addr,
    output logic        mem_rd_n,
    output logic        mem_wr_n,
    output logic        io_rd_n,
    output logic        io_wr_n,
    output logic        tc
);
    localparam int NCH = dma4_pkg::NCH_DEF;
    localparam int AW  = dma4_pkg::AW_DEF;
    localparam int CW  = dma4_pkg::CW_DEF;
    localparam int CAW = $clog2(NCH);

    logic [NCH-1:0][AW-1:0] ch_addr;
    logic [NCH-1:0][1:0]    ch_typ;
    logic [NCH-1:0]         ch_last;
    logic [NCH-1:0]         ch_live;
    logic [NCH-1:0]         arb_req;
    logic [CAW-1:0]         arb_idx;
    logic                   arb_any;
    logic                   upd;
    logic [CAW-1:0]         upd_ch;

    dma4_regs #(.NCH(NCH), .AW(AW), .CW(CW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .lock      (hlda),
        .upd       (upd),
        .upd_ch    (upd_ch),
        .ch_addr   (ch_addr),
        .ch_typ    (ch_typ),
        .ch_last   (ch_last),
        .ch_live   (ch_live)
    );

    dma4_arb #(.NCH(NCH)) u_arb (
        .req     (arb_req),
        .win_idx (arb_idx),
        .win_any (arb_any)
    );

    dma4_seq #(.NCH(NCH), .AW(AW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .hlda     (hlda),
        .drq      (drq),
        .ch_live  (ch_live),
        .ch_last  (ch_last),
        .ch_addr  (ch_addr),
        .ch_typ   (ch_typ),
        .arb_any  (arb_any),
        .arb_idx  (arb_idx),
        .arb_req  (arb_req),
        .hrq      (hrq),
        .dack_n   (dack_n),
        .mem_addr (mem_addr),
        .mem_rd_n (mem_rd_n),
        .mem_wr_n (mem_wr_n),
        .io_rd_n  (io_rd_n),
        .io_wr_n  (io_wr_n),
        .tc       (tc),
        .upd      (upd),
        .upd_ch   (upd_ch)
    );

endmodule

// File: tb/sim_dma4_ctrl.sv
// Scoreboard bench: stimulus tasks queue the expected transfers
// {tc, type, channel, address}; a monitor at the falling edge tracks the four
// transfer states and compares each one against the head of the queue.
module sim_dma4_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [3:0]  drq = '0;
    logic        hlda = 1'b0;
    logic        hrq;
    logic [3:0]  dack_n;
    logic [15:0] mem_addr;
    logic        mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, tc;

    int nchk = 0;
    int nfail = 0;
    bit auto_ack = 1'b1;
    bit done = 1'b0;
    logic [20:0] expq[$];

    dma4_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .drq(drq), .hlda(hlda), .hrq(hrq),
        .dack_n(dack_n), .mem_addr(mem_addr), .mem_rd_n(mem_rd_n),
        .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .tc(tc)
    );

    always #5 clk = ~clk;

    // Processor model: grants the bus one clock after the hold request.
    always @(posedge clk) hlda <= auto_ack && hrq;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] strobes_for(input logic [1:0] typ);
        // {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}
        case (typ)
            2'b10:   return 4'b0110;
            2'b01:   return 4'b1001;
            default: return 4'b1111;
        endcase
    endfunction

    task automatic expect_xfer(input logic [1:0] ch, input logic [15:0] a, input logic [1:0] typ, input logic last);
        expq.push_back({last, typ, ch, a});
    endtask

    task automatic wr_now(input logic [1:0] ch, input logic [1:0] sel, input logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = {ch, sel}; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr(input logic [1:0] ch, input logic [1:0] sel, input logic [15:0] d);
        while (hlda) @(negedge clk);
        wr_now(ch, sel, d);
    endtask

    task automatic prog(input logic [1:0] ch, input logic [15:0] a, input logic [13:0] cnt,
                        input logic [1:0] typ, input logic en);
        wr(ch, 2'd0, a);
        wr(ch, 2'd1, {typ, cnt});
        wr(ch, 2'd2, {15'd0, en});
    endtask

    task automatic wait_done();
        int n = 0;
        while ((expq.size() != 0 || hrq) && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk("R7", "queue drained and hold released", (n < 5000), 1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: follows the transfer states and scores each transfer.
    int phase = 0;
    logic [20:0] cur;
    always @(negedge clk) begin
        if (rst_n) begin
            if (dack_n != 4'hF) begin
                phase = (phase == 0 || phase == 4) ? 1 : phase + 1;
                if (phase == 1) begin
                    if (expq.size() == 0) begin
                        chk("R1", "unexpected transfer dack_n", {28'd0, dack_n}, 32'hF);
                        cur = '0;
                    end else begin
                        cur = expq.pop_front();
                        chk("R1", "served channel dack_n", {28'd0, dack_n}, {28'd0, ~(4'b1 << cur[17:16])});
                        chk("R5", "transfer address", {16'd0, mem_addr}, {16'd0, cur[15:0]});
                    end
                    chk("R4", "strobes idle in state 1", {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, 4'hF);
                    chk("R6", "tc low in state 1", tc, 0);
                end else if (phase == 2 || phase == 3) begin
                    chk("R4", "strobes in state 2/3", {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n},
                        {28'd0, strobes_for(cur[19:18])});
                    chk("R6", "tc low in state 2/3", tc, 0);
                end else begin
                    chk("R4", "strobes idle in state 4", {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, 4'hF);
                    chk("R6", "tc in state 4", tc, cur[20]);
                    chk("R5", "address held in state 4", {16'd0, mem_addr}, {16'd0, cur[15:0]});
                end
            end else begin
                if (phase != 0 && phase != 4)
                    chk("R3", "acknowledge length in states", phase, 4);
                phase = 0;
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk("R2", "hrq after reset", hrq, 0);
        chk("R3", "dack_n after reset", dack_n, 4'hF);
        chk("R4", "strobes after reset", {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, 4'hF);
        chk("R6", "tc after reset", tc, 0);
        chk("R2", "address after reset", mem_addr, 0);

        // R10: disabled channel does not raise a hold request
        prog(2'd0, 16'h1000, 14'd3, 2'b10, 1'b0);
        drq = 4'b0001;
        idle(6);
        chk("R10", "hrq for disabled channel", hrq, 0);

        // Single channel, three reads, then self-disable
        expect_xfer(2'd0, 16'h1000, 2'b10, 1'b0);
        expect_xfer(2'd0, 16'h1001, 2'b10, 1'b0);
        expect_xfer(2'd0, 16'h1002, 2'b10, 1'b1);
        wr(2'd0, 2'd2, 16'h0001);
        idle(2);
        chk("R2", "hrq raised for enabled request", hrq, 1);
        wait_done();
        idle(6);
        chk("R6", "hrq stays low after terminal count", hrq, 0);
        drq = 4'b0000;

        // R10: zero count is not eligible; R8: register code 3 is inert
        prog(2'd1, 16'h0000, 14'd0, 2'b01, 1'b1);
        wr(2'd1, 2'd3, 16'h0007);
        drq = 4'b0010;
        idle(6);
        chk("R10", "hrq for zero-count channel", hrq, 0);
        drq = 4'b0000;

        // Priority, mid-transfer arrival, wrap, locked write
        prog(2'd0, 16'h0040, 14'd1, 2'b10, 1'b1);
        prog(2'd1, 16'h2000, 14'd2, 2'b01, 1'b1);
        prog(2'd2, 16'h3000, 14'd1, 2'b10, 1'b1);
        prog(2'd3, 16'hFFFF, 14'd2, 2'b00, 1'b1);
        expect_xfer(2'd1, 16'h2000, 2'b01, 1'b0);
        expect_xfer(2'd0, 16'h0040, 2'b10, 1'b1);
        expect_xfer(2'd1, 16'h2001, 2'b01, 1'b1);
        expect_xfer(2'd2, 16'h3000, 2'b10, 1'b1);
        expect_xfer(2'd3, 16'hFFFF, 2'b00, 1'b0);
        expect_xfer(2'd3, 16'h0000, 2'b00, 1'b1);
        drq = 4'b1110;
        while (dack_n[1]) @(negedge clk);
        drq = 4'b1111;          // R1: arrives during channel 1's transfer
        chk("R9", "hold granted before locked write", hlda, 1);
        wr_now(2'd2, 2'd0, 16'h5555);   // R9: must be ignored
        wait_done();
        drq = 4'b0000;

        // R2: no bus activity until the grant
        auto_ack = 1'b0;
        prog(2'd2, 16'h0ABC, 14'd1, 2'b01, 1'b1);
        drq = 4'b0100;
        idle(6);
        chk("R2", "hrq while waiting", hrq, 1);
        chk("R2", "dack_n while waiting", dack_n, 4'hF);
        chk("R2", "strobes while waiting", {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, 4'hF);
        chk("R2", "address while waiting", mem_addr, 0);
        expect_xfer(2'd2, 16'h0ABC, 2'b01, 1'b1);
        auto_ack = 1'b1;
        wait_done();
        drq = 4'b0000;
        idle(4);
        chk("R7", "scoreboard empty at end", expq.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule